// File: doc/BRIEF.md
# Keyed Write Gate for Watchdog Configuration

This block guards writes to the watchdog's configuration. A write of a fixed key value to an unlock address opens a short window. The window lasts a set number of retired instructions. Only inside that window can a bus write reach the watchdog control register or the lock bit of the watchdog status register.

The block sits between the bus write port and those two registers. For each protected target it drives a write enable. That enable is asserted only for a bus write that hits the target while the window is open. Any other write to a target is taken by the bus without error, but no enable is raised, so the stored value does not change. An output reports whether the window is open at present.

Top module: `cfg_key_gate`

## Requirements
- R1: A bus write of data 0xD8 to the unlock address (default 0x34) opens the window from the next cycle. `win_open` goes to 1 and the counter is loaded with WINDOW (default 4).
- R2: `ctrl_we` is 1 in the same cycle as a bus write to the control address (default 0x80) only while `win_open` is 1. `stat_we` is 1 in the same cycle as a bus write to the status address (default 0x81) only while `win_open` is 1.
- R3: Writes to the control or status address while the window is closed produce no enable. Writes to any other address never produce an enable and leave the window state unchanged.
- R4: Each `retire` pulse lowers the counter by one while the window is open. The window closes after WINDOW pulses, so a protected write is accepted only within four instructions after the key write.
- R5: A protected write that is accepted closes the window from the next cycle.
- R6: A write to the unlock address with any data other than 0xD8 closes an open window and does not open a closed one.
- R7: A correct key write while the window is open reloads the counter to WINDOW. A key write in the same cycle as a `retire` pulse still loads the full WINDOW.
- R8: Reset closes the window. After reset, no enable is raised until a new key write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | ADDR_W | Bus write address |
| wr_data | input | DATA_W | Bus write data |
| retire | input | 1 | One pulse per retired instruction |
| ctrl_we | output | 1 | Gated write enable, watchdog control register |
| stat_we | output | 1 | Gated write enable, lock bit of watchdog status |
| win_open | output | 1 | The protected-write window is open |

## Verification
The gated enables are combinational, so they are due in the same cycle as the write that causes them. The bench drives each input vector just after a falling edge and samples `ctrl_we` and `stat_we` one nanosecond later, before the next rising edge. `win_open` comes from the counter register, so it changes one rising edge after the key write, retire pulse or accepted write. The bench reads it just after that edge, which places each window-state check one cycle behind its stimulus.

// File: rtl/cfg_key_gate.sv
module cfg_key_gate #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int WINDOW = 4,
  parameter logic [DATA_W-1:0] KEY_VAL = 8'hD8,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 8'h34,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h80,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h81
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              retire,
  output logic              ctrl_we,
  output logic              stat_we,
  output logic              win_open
);
  localparam int CW = $clog2(WINDOW + 1);
  localparam logic [CW-1:0] LOAD = CW'(WINDOW);

  logic [CW-1:0] cnt;

  wire key_hit  = wr_en && (wr_addr == KEY_ADDR);
  wire key_good = key_hit && (wr_data == KEY_VAL);
  wire any_prot = ctrl_we || stat_we;

  assign win_open = (cnt != '0);
  assign ctrl_we  = wr_en && (wr_addr == CTRL_ADDR) && win_open;
  assign stat_we  = wr_en && (wr_addr == STAT_ADDR) && win_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (key_good)        cnt <= LOAD;
    else if (key_hit)         cnt <= '0;
    else if (any_prot)        cnt <= '0;
    else if (retire && win_open) cnt <= cnt - 1'b1;
  end
endmodule

module cfg_key_gate_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int WINDOW = 4,
  parameter logic [DATA_W-1:0] KEY_VAL = 8'hD8,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 8'h34,
  parameter int CW = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              retire,
  input logic              ctrl_we,
  input logic              stat_we,
  input logic              win_open,
  input logic [CW-1:0]     cnt
);
  wire key_hit  = wr_en && (wr_addr == KEY_ADDR);
  wire key_good = key_hit && (wr_data == KEY_VAL);

  p_key_opens_r1: assert property (@(posedge clk) disable iff (!rst_n)
    key_good |=> win_open && (cnt == CW'(WINDOW)));
  p_gate_needs_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we || stat_we) |-> win_open);
  p_one_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl_we, stat_we}));
  p_retire_counts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && win_open && !wr_en) |=> (cnt == $past(cnt) - 1'b1));
  p_close_on_use_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we || stat_we) |=> !win_open);
  p_bad_key_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (key_hit && !key_good) |=> !win_open);
  p_stay_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_open && !key_good) |=> !win_open);
endmodule

bind cfg_key_gate cfg_key_gate_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WINDOW(WINDOW),
  .KEY_VAL(KEY_VAL), .KEY_ADDR(KEY_ADDR), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .retire(retire), .ctrl_we(ctrl_we),
  .stat_we(stat_we), .win_open(win_open), .cnt(cnt)
);

// File: tb/cfg_key_gate_bench.sv
`timescale 1ns/1ps
module cfg_key_gate_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic retire = 1'b0;
  logic ctrl_we, stat_we, win_open;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cfg_key_gate u_cfg_key_gate (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .retire(retire), .ctrl_we(ctrl_we),
    .stat_we(stat_we), .win_open(win_open)
  );

  // {wr, ret, addr, data, exp_ctrl, exp_stat, exp_open_after}
  localparam int NV = 30;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0,1'b0,8'h00,8'h00,1'b0,1'b0,1'b0}, // R8 idle after reset
    {1'b1,1'b0,8'h80,8'h01,1'b0,1'b0,1'b0}, // R3 ctrl closed
    {1'b1,1'b0,8'h81,8'h01,1'b0,1'b0,1'b0}, // R3 stat closed
    {1'b1,1'b0,8'h34,8'hD8,1'b0,1'b0,1'b1}, // R1 key
    {1'b1,1'b0,8'h80,8'h05,1'b1,1'b0,1'b0}, // R2 R5 ctrl accepted
    {1'b1,1'b0,8'h80,8'h05,1'b0,1'b0,1'b0}, // R5 second refused
    {1'b1,1'b0,8'h34,8'hD8,1'b0,1'b0,1'b1}, // R1
    {1'b0,1'b1,8'h00,8'h00,1'b0,1'b0,1'b1}, // R4 ret1
    {1'b0,1'b1,8'h00,8'h00,1'b0,1'b0,1'b1}, // R4 ret2
    {1'b0,1'b1,8'h00,8'h00,1'b0,1'b0,1'b1}, // R4 ret3
    {1'b1,1'b0,8'h81,8'h01,1'b0,1'b1,1'b0}, // R2 stat accepted
    {1'b1,1'b0,8'h34,8'hD8,1'b0,1'b0,1'b1}, // R1
    {1'b1,1'b0,8'h10,8'hFF,1'b0,1'b0,1'b1}, // R3 other addr
    {1'b0,1'b1,8'h00,8'h00,1'b0,1'b0,1'b1}, // R4
    {1'b0,1'b1,8'h00,8'h00,1'b0,1'b0,1'b1},
    {1'b0,1'b1,8'h00,8'h00,1'b0,1'b0,1'b1},
    {1'b0,1'b1,8'h00,8'h00,1'b0,1'b0,1'b0}, // R4 fourth closes
    {1'b1,1'b0,8'h80,8'h05,1'b0,1'b0,1'b0}, // R4 late write refused
    {1'b1,1'b0,8'h34,8'hD8,1'b0,1'b0,1'b1}, // R1
    {1'b1,1'b0,8'h34,8'h55,1'b0,1'b0,1'b0}, // R6 wrong key closes
    {1'b1,1'b0,8'h80,8'h05,1'b0,1'b0,1'b0}, // R6
    {1'b1,1'b0,8'h34,8'hD7,1'b0,1'b0,1'b0}, // R6 no open
    {1'b1,1'b0,8'h34,8'hD8,1'b0,1'b0,1'b1}, // R1
    {1'b0,1'b1,8'h00,8'h00,1'b0,1'b0,1'b1},
    {1'b0,1'b1,8'h00,8'h00,1'b0,1'b0,1'b1},
    {1'b1,1'b1,8'h34,8'hD8,1'b0,1'b0,1'b1}, // R7 reload with retire
    {1'b0,1'b1,8'h00,8'h00,1'b0,1'b0,1'b1},
    {1'b0,1'b1,8'h00,8'h00,1'b0,1'b0,1'b1},
    {1'b0,1'b1,8'h00,8'h00,1'b0,1'b0,1'b1}, // R7 still open after 3
    {1'b1,1'b1,8'h80,8'h07,1'b1,1'b0,1'b0}  // R7 R2 accepted
  };

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic apply(input logic w, input logic r, input logic [7:0] a,
                       input logic [7:0] d, input logic ec, input logic es,
                       input logic eo, input string req);
    @(negedge clk);
    wr_en = w; retire = r; wr_addr = a; wr_data = d;
    #1;
    chk({req, " ctrl_we"}, ctrl_we, ec);
    chk({req, " stat_we"}, stat_we, es);
    @(posedge clk);
    #1;
    wr_en = 1'b0; retire = 1'b0;
    chk({req, " win_open"}, win_open, eo);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R8 reset win_open", win_open, 1'b0);
    chk("R8 reset ctrl_we", ctrl_we, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      logic [20:0] v;
      v = VEC[i];
      apply(v[20], v[19], v[18:11], v[10:3], v[2], v[1], v[0],
            $sformatf("vec%0d", i));
    end
    // R8: reset in the middle of an open window
    apply(1'b1, 1'b0, 8'h34, 8'hD8, 1'b0, 1'b0, 1'b1, "R8 key");
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R8 reset closes", win_open, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    apply(1'b1, 1'b0, 8'h81, 8'h01, 1'b0, 1'b0, 1'b0, "R8 after reset");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule